// File: doc/BRIEF.md
# Disc Write Permit and Abort Status

This block sits between a disc controller's command logic and the write path. It keeps a registered track address and, for every address bit, a configuration bit that says whether that bit takes part in the protection test. With the protection switch enabled, a track is protected when all examined address bits are zero. The protected region is therefore a power-of-two block of tracks that starts at track zero. Its size is chosen by which bits are left unexamined. A protected track drops the write-permit output. With the switch disabled, every track may be written.

The block also records whether a write may have failed. A start-write strobe begins a write and clears a sticky abort flag. During the write, the flag is set if the drive stops reporting ready or if the AC line stops reporting good. Both of those inputs are re-timed through a two-flop synchronizer. The flag stays set until the next start-write, even after the write is stopped. Software reads the flag and a write-in-progress bit from a status word.

There is no streaming data at this block's edge. Every pin is a plain level or a single-cycle strobe, and no back-pressure exists. The mask and the switch are static configuration.

Top module: `disc_write_guard`

## Requirements
- R1: After reset the track register holds 0, and status_word reads 0x00 (abort flag clear, no write in progress).
- R2: A high addr_load at a rising clock edge loads addr_in into the track register. write_permit reflects the new track immediately after that edge.
- R3: With protect_en high, write_permit is 0 exactly when the track AND examine_mask is zero. Otherwise it is 1. A 1 in examine_mask means that address bit is examined.
- R4: With examine_mask = 0xFF and protect_en high, only track 0 is protected. Mask 0xFE protects tracks 0 and 1, and mask 0xF8 protects tracks 0 to 7.
- R5: With examine_mask = 0x00 and protect_en high, every track is protected.
- R6: With protect_en low, write_permit is 1 for every track and every mask.
- R7: A start_write strobe clears the abort flag (status bit 3) and sets the write-in-progress bit (status bit 0) at the next edge.
- R8: While a write is in progress, drive_ready low or ac_good low sets status bit 3. The flag rises on the third rising edge after the input changes, because of the two-flop synchronizer.
- R9: The abort flag stays set until the next start_write. A write_stop strobe clears status bit 0 and leaves bit 3 unchanged.
- R10: A fault on drive_ready or ac_good while no write is in progress leaves status bit 3 at 0.
- R11: When start_write arrives while a synchronized fault is present, bit 3 reads 0 after that edge. It reads 1 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Strobe that loads addr_in into the track register |
| addr_in | input | 8 | Track address to load |
| examine_mask | input | 8 | Per-address-bit examine enable (1 = examined) |
| protect_en | input | 1 | Protection switch, 1 = protection active |
| start_write | input | 1 | Start-write strobe |
| write_stop | input | 1 | End-of-write strobe |
| drive_ready | input | 1 | Drive ready, 1 = ready |
| ac_good | input | 1 | AC line good, 1 = good |
| write_permit | output | 1 | 1 when a write to the current track is allowed |
| status_word | output | 8 | Bit 3 = abort flag, bit 0 = write in progress, other bits 0 |

## Verification
The bench walks the protected range through its edges for several masks: track 0 against track 1 with a full mask, 1 against 2 with bit 0 ignored, and 7 against 8 with three bits ignored. A comparator that tests the wrong polarity, or that ignores the mask, would move these edges. It checks the abort flag at the second and third edges after a fault. A design with a missing or extra synchronizer stage would show the flag one cycle early or late. It also checks that faults outside a write leave the flag alone, that write_stop does not clear the flag, and that start_write wins over a fault in the same cycle. A wrong priority would leave the flag set after a fresh start.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int ABORT_BIT = 3;
  localparam int BUSY_BIT  = 0;

  typedef enum logic {
    WR_IDLE   = 1'b0,
    WR_ACTIVE = 1'b1
  } wr_state_e;
endpackage

// File: rtl/dwg_sync2.sv
module dwg_sync2 #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/dwg_track_match.sv
module dwg_track_match #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] track,
  input  logic [ADDR_W-1:0] examine,
  output logic              in_range
);
  logic [ADDR_W-1:0] hit_bit;

  // A bit counts against protection only when it is examined and set.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign hit_bit[i] = examine[i] & track[i];
  end

  assign in_range = ~|hit_bit;
endmodule

// File: rtl/dwg_abort_ctl.sv
module dwg_abort_ctl
  import dwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_write,
  input  logic write_stop,
  input  logic fault_sync,
  output logic busy,
  output logic abort_flag
);
  wr_state_e state_q;
  wr_state_e state_d;
  logic      abort_q;
  logic      abort_d;

  always_comb begin
    state_d = state_q;
    abort_d = abort_q;
    if (start_write) begin
      state_d = WR_ACTIVE;
      abort_d = 1'b0;
    end else begin
      if (state_q == WR_ACTIVE && fault_sync) abort_d = 1'b1;
      if (write_stop) state_d = WR_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  assign busy       = (state_q == WR_ACTIVE);
  assign abort_flag = abort_q;
endmodule

// File: rtl/disc_write_guard.sv
module disc_write_guard
  import dwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] examine_mask,
  input  logic              protect_en,
  input  logic              start_write,
  input  logic              write_stop,
  input  logic              drive_ready,
  input  logic              ac_good,
  output logic              write_permit,
  output logic [STAT_W-1:0] status_word
);
  localparam int SYNC_W = 2;

  logic [ADDR_W-1:0] addr_q;
  logic              in_range;
  logic [SYNC_W-1:0] health_s;
  logic              fault_sync;
  logic              busy;
  logic              abort_flag;

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_load) addr_q <= addr_in;
  end

  dwg_track_match #(.ADDR_W(ADDR_W)) u_match (
    .track    (addr_q),
    .examine  (examine_mask),
    .in_range (in_range)
  );

  assign write_permit = !(protect_en && in_range);

  dwg_sync2 #(.WIDTH(SYNC_W), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ac_good, drive_ready}),
    .dout  (health_s)
  );

  assign fault_sync = ~&health_s;

  dwg_abort_ctl u_abort (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_write (start_write),
    .write_stop  (write_stop),
    .fault_sync  (fault_sync),
    .busy        (busy),
    .abort_flag  (abort_flag)
  );

  always_comb begin
    status_word            = '0;
    status_word[ABORT_BIT] = abort_flag;
    status_word[BUSY_BIT]  = busy;
  end
endmodule

// File: rtl/dwg_checker.sv
module dwg_checker #(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] examine_mask,
  input logic              protect_en,
  input logic              start_write,
  input logic              write_permit,
  input logic [STAT_W-1:0] status_word
);
  // R3
  protected_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_en && ((addr_q & examine_mask) == '0)) |-> !write_permit);

  // R6
  unprotected_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !protect_en |-> write_permit);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_write |=> (!status_word[3] && status_word[0]));

  // R9
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[3] && !start_write) |=> status_word[3]);

  // R8
  abort_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[3]) |-> $past(status_word[0]));

  // R10
  idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[0] && !status_word[3] && !start_write) |=> !status_word[3]);
endmodule

bind disc_write_guard dwg_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_q       (addr_q),
  .examine_mask (examine_mask),
  .protect_en   (protect_en),
  .start_write  (start_write),
  .write_permit (write_permit),
  .status_word  (status_word)
);

// File: tb/disc_write_guard_bench.sv
module disc_write_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_load;
  logic [7:0] addr_in;
  logic [7:0] examine_mask;
  logic       protect_en;
  logic       start_write;
  logic       write_stop;
  logic       drive_ready;
  logic       ac_good;
  logic       write_permit;
  logic [7:0] status_word;

  int n_cmp  = 0;
  int n_miss = 0;
  bit done   = 1'b0;

  string      q_tag[$];
  logic       q_perm[$];
  logic [7:0] q_stat[$];
  event       exp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  disc_write_guard u_disc_write_guard (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .examine_mask(examine_mask), .protect_en(protect_en),
    .start_write(start_write), .write_stop(write_stop),
    .drive_ready(drive_ready), .ac_good(ac_good),
    .write_permit(write_permit), .status_word(status_word)
  );

  // Driver side: push the expected values, then wake the monitor.
  task automatic expect_out(input string tag, input logic perm, input logic [7:0] stat);
    q_tag.push_back(tag);
    q_perm.push_back(perm);
    q_stat.push_back(stat);
    ->exp_ev;
    #2;
  endtask

  // Monitor: pop and compare while inputs are held steady.
  initial begin
    forever begin
      @(exp_ev);
      #1;
      while (q_tag.size() > 0) begin
        string      t;
        logic       p;
        logic [7:0] s;
        t = q_tag.pop_front();
        p = q_perm.pop_front();
        s = q_stat.pop_front();
        n_cmp++;
        if (write_permit !== p || status_word !== s) begin
          n_miss++;
          $display("FAIL %s: permit=%0b status=%02h expected permit=%0b status=%02h",
                   t, write_permit, status_word, p, s);
        end
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_track(input logic [7:0] a);
    addr_in   = a;
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic pulse_start();
    start_write = 1'b1;
    @(negedge clk);
    start_write = 1'b0;
  endtask

  task automatic pulse_stop();
    write_stop = 1'b1;
    @(negedge clk);
    write_stop = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; addr_load = 1'b0; addr_in = 8'h00; examine_mask = 8'hFF;
    protect_en = 1'b1; start_write = 1'b0; write_stop = 1'b0;
    drive_ready = 1'b1; ac_good = 1'b1;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    expect_out("R1 reset", 1'b0, 8'h00);

    // R2 / R4: full mask, only track 0 protected
    load_track(8'h01); expect_out("R2 load track 1", 1'b1, 8'h00);
    load_track(8'h00); expect_out("R4 track 0 mask FF", 1'b0, 8'h00);
    load_track(8'h80); expect_out("R4 track 80 mask FF", 1'b1, 8'h00);

    // R3: bit 0 ignored
    examine_mask = 8'hFE;
    load_track(8'h01); expect_out("R3 track 1 mask FE", 1'b0, 8'h00);
    load_track(8'h02); expect_out("R3 track 2 mask FE", 1'b1, 8'h00);
    examine_mask = 8'hF8;
    load_track(8'h07); expect_out("R4 track 7 mask F8", 1'b0, 8'h00);
    load_track(8'h08); expect_out("R4 track 8 mask F8", 1'b1, 8'h00);

    // R5: nothing examined
    examine_mask = 8'h00;
    load_track(8'hFF); expect_out("R5 track FF mask 00", 1'b0, 8'h00);

    // R6: switch off
    protect_en = 1'b0;
    expect_out("R6 switch off mask 00", 1'b1, 8'h00);
    examine_mask = 8'hFF;
    load_track(8'h00); expect_out("R6 switch off track 0", 1'b1, 8'h00);

    // R10: fault while idle
    drive_ready = 1'b0;
    cycles(5); expect_out("R10 idle fault", 1'b1, 8'h00);
    drive_ready = 1'b1;
    cycles(3);

    // R7
    pulse_start(); expect_out("R7 start", 1'b1, 8'h01);

    // R8 latency via drive_ready
    drive_ready = 1'b0;
    cycles(2); expect_out("R8 before third edge", 1'b1, 8'h01);
    cycles(1); expect_out("R8 abort set by ready", 1'b1, 8'h09);
    drive_ready = 1'b1;
    cycles(4); expect_out("R9 sticky", 1'b1, 8'h09);
    pulse_stop(); expect_out("R9 stop keeps flag", 1'b1, 8'h08);
    pulse_start(); expect_out("R7 restart clears", 1'b1, 8'h01);

    // R8 via ac_good
    ac_good = 1'b0;
    cycles(3); expect_out("R8 abort set by ac", 1'b1, 8'h09);

    // R11: start while synchronized fault present
    pulse_start(); expect_out("R11 start wins", 1'b1, 8'h01);
    cycles(1);     expect_out("R11 fault next edge", 1'b1, 8'h09);
    ac_good = 1'b1;
    cycles(3);
    pulse_stop(); expect_out("R9 stop after R11", 1'b1, 8'h08);

    cycles(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_miss++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
    end
  end
endmodule